// File: doc/BRIEF.md
# Bidirectional GPIO Port with Keyboard-Wakeup Override

An eight-pin general-purpose I/O port with two bus registers: an output latch and a direction register. A pin whose direction bit is 1 drives the latched value on its pad. A pin whose direction bit is 0 is a plain input. Software reads the pin levels through the latch address. External pin levels pass through a two-stage synchronizer before the read path sees them.

Six of the pins, pins 1 to 6, can also be claimed by an external keyboard-wakeup controller. That controller supplies one enable per pin. An active enable turns the pin's driver off whatever its direction bit says, and it turns on the pin's internal pullup.

The latch has no reset and keeps its contents across a reset. The direction register clears on reset, so every pin comes out of reset as an input. The output value, output-enable and pullup-enable vectors leave the block as three separate buses for a pad model. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `gpio_kbw_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction register reads 0x00 and `pad_oe` is 0x00.
- R2: A reset does not alter the output latch; the value written before a reset still reads back and drives `pad_out` after it.
- R3: A write with `bus_wr` high updates the output latch when `bus_addr` is 0 and the direction register when `bus_addr` is 4, taking effect at that rising clock edge. The direction register reads back at address 4, and `bus_addr` is 3 bits wide.
- R4: For a pin with no keyboard enable active, `pad_oe[i]` equals direction bit i.
- R5: `kbw_en[k]` belongs to pin k+1. While it is high, `pad_oe[k+1]` is 0 and `pad_pu[k+1]` is 1. `pad_pu[0]` and `pad_pu[7]` are always 0.
- R6: A read at address 0 returns the latch bit for pins with direction 1 and the synchronized pin level for pins with direction 0. This holds even for a pin with its keyboard enable active.
- R7: `pad_out` always equals the output latch, so a pin whose direction bit goes from 0 to 1 drives the most recently written value on its first enabled cycle.
- R8: A change on `pin_in` shows up in the address-0 read data after exactly two rising clock edges.
- R9: Reads at addresses 1, 2, 3, 5, 6 and 7 return 0x00, and writes to those addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| kbw_en | input | 6 | Keyboard-wakeup enables for pins 1..6 |
| pad_out | output | 8 | Output value per pin |
| pad_oe | output | 8 | Output-driver enable per pin |
| pad_pu | output | 8 | Pullup enable per pin |

## Verification
The bench first targets the switch of a pin's direction from input to output just after a latch write. A design that registered the pad value one stage later would drive the stale value for one cycle.

It resets in mid-run and then reads the latch back. A design that reset the latch would return zeros.

It raises keyboard enables over pins whose direction bit is 1, and it drives unmapped addresses. A missing override would leave the pin driven with no pullup. A loose address decode would corrupt a register or leak read data.

It changes pin levels and counts edges until the read data follows. A synchronizer with the wrong depth would show up one cycle early or late.

// File: rtl/gpio_kbw_pkg.sv
package gpio_kbw_pkg;
  localparam int unsigned GPIO_W   = 8;
  localparam int unsigned KBW_LO   = 1;
  localparam int unsigned KBW_N    = 6;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned LAT_OFS  = 0;
  localparam int unsigned DIR_OFS  = 4;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_sync_n = q2;
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_async;
      s2_q <= s1_q;
    end
  end

  assign pin_sync = s2_q;

  // R8: second stage follows the first one edge later
  assert_sync_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s2_q == $past(s1_q));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned W       = 8,
  parameter int unsigned AW      = 3,
  parameter int unsigned LAT_A   = 0,
  parameter int unsigned DIR_A   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  lat_q,
  output logic [W-1:0]  dir_q
);
  localparam logic [AW-1:0] LatSel = AW'(LAT_A);
  localparam logic [AW-1:0] DirSel = AW'(DIR_A);

  logic         lat_we, dir_we;
  logic [W-1:0] lat_d, dir_d;

  always_comb begin
    lat_we = wr && (addr == LatSel);
    dir_we = wr && (addr == DirSel);
    lat_d  = wdata;
    dir_d  = wdata;
  end

  // Output latch: deliberately without reset
  always_ff @(posedge clk) begin
    if (lat_we) lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= dir_d;
  end

  assert_lat_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == LatSel) |=> lat_q == $past(wdata));
  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == DirSel) |=> dir_q == $past(wdata));
  // R9: a write elsewhere leaves the direction register alone
  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == DirSel) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned KLO   = 1,
  parameter int unsigned KN    = 6,
  parameter int unsigned LAT_A = 0,
  parameter int unsigned DIR_A = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  lat_q,
  input  logic [W-1:0]  dir_q,
  input  logic [W-1:0]  pin_s,
  input  logic [KN-1:0] kbw_en,
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu,
  output logic [W-1:0]  rdata
);
  localparam logic [AW-1:0] LatSel = AW'(LAT_A);
  localparam logic [AW-1:0] DirSel = AW'(DIR_A);

  logic [W-1:0] kb_full;
  logic [W-1:0] pin_view;

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i >= KLO && i < KLO + KN) begin : g_kbw
      assign kb_full[i] = kbw_en[i-KLO];
    end else begin : g_plain
      assign kb_full[i] = 1'b0;
    end
    assign pin_view[i] = dir_q[i] ? lat_q[i] : pin_s[i];
  end

  always_comb begin
    pad_out = lat_q;
    pad_oe  = dir_q & ~kb_full;
    pad_pu  = kb_full;
    case (addr)
      LatSel:  rdata = pin_view;
      DirSel:  rdata = dir_q;
      default: rdata = '0;
    endcase
  end

  assert_kbw_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);
  assert_oe_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);
endmodule

// File: rtl/gpio_kbw_port.sv
module gpio_kbw_port
  import gpio_kbw_pkg::*;
#(
  parameter int unsigned W     = GPIO_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned KLO   = KBW_LO,
  parameter int unsigned KN    = KBW_N,
  parameter int unsigned LAT_A = LAT_OFS,
  parameter int unsigned DIR_A = DIR_OFS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  input  logic [KN-1:0] kbw_en,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu
);
  logic         rst_i_n;
  logic [W-1:0] lat_q, dir_q, pin_s;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  gpio_pin_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .pin_async(pin_in), .pin_sync(pin_s));

  gpio_regs #(.W(W), .AW(AW), .LAT_A(LAT_A), .DIR_A(DIR_A)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .lat_q(lat_q), .dir_q(dir_q));

  gpio_pad_ctrl #(.W(W), .AW(AW), .KLO(KLO), .KN(KN),
                  .LAT_A(LAT_A), .DIR_A(DIR_A)) u_pad (
    .clk(clk), .rst_n(rst_i_n), .lat_q(lat_q), .dir_q(dir_q),
    .pin_s(pin_s), .kbw_en(kbw_en), .addr(bus_addr),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .rdata(bus_rdata));

  // R1: on the edge where internal reset is seen released, no pin drives
  assert_reset_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_i_n) |-> pad_oe == '0);
  // R7: the pad value never lags the latch
  assert_pad_tracks_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && bus_addr == AW'(LAT_A)) |=> pad_out == $past(bus_wdata));
endmodule

// File: tb/gpio_kbw_port_test.sv
module gpio_kbw_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in;
  logic [5:0] kbw_en;
  logic [7:0] pad_out, pad_oe, pad_pu;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  int ref_lat, ref_dir, ref_s1, ref_s2, ref_rcnt;
  bit lat_known = 1'b0;

  always #10 clk = ~clk;

  gpio_kbw_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .kbw_en(kbw_en), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  function automatic int kb_pins(input int kb);
    return (kb & 32'h3F) << 1;
  endfunction

  function automatic int exp_rdata(input int a);
    int r = 0;
    if (a == 0) begin
      for (int i = 0; i < 8; i++)
        if ((ref_dir >> i) & 1) r |= ref_lat & (1 << i);
        else                    r |= ref_s2  & (1 << i);
    end else if (a == 4) r = ref_dir;
    return r;
  endfunction

  // Reference update at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_dir = 0; ref_s1 = 0; ref_s2 = 0; ref_rcnt = 0;
    end else begin
      if (ref_rcnt >= 2) begin
        if (bus_wr && bus_addr == 3'd0) begin ref_lat = int'(bus_wdata); lat_known = 1'b1; end
        if (bus_wr && bus_addr == 3'd4) ref_dir = int'(bus_wdata);
        ref_s2 = ref_s1;
        ref_s1 = int'(pin_in);
      end else if (bus_wr && bus_addr == 3'd0) begin
        // latch has no reset: it still captures during the reset window
        ref_lat = int'(bus_wdata); lat_known = 1'b1;
      end
      if (ref_rcnt < 2) ref_rcnt++;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check("R1 R4 R5 pad_oe", int'(pad_oe), ref_dir & ~kb_pins(int'(kbw_en)) & 8'hFF);
      check("R5 pad_pu", int'(pad_pu), kb_pins(int'(kbw_en)));
      if (lat_known) begin
        check("R2 R7 pad_out", int'(pad_out), ref_lat);
        check("R3 R6 R8 R9 bus_rdata", int'(bus_rdata), exp_rdata(int'(bus_addr)));
      end else if (bus_addr != 3'd0) begin
        check("R3 R9 bus_rdata", int'(bus_rdata), exp_rdata(int'(bus_addr)));
      end
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #2;
    bus_wr = 1'b0; bus_addr = 3'd0;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input int exp);
    @(negedge clk); #2;
    bus_addr = a;
    @(negedge clk); #1;
    check(tag, int'(bus_rdata), exp);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 3'd4; bus_wdata = 8'h00;
    pin_in = 8'h00; kbw_en = 6'h00;
    idle(3);
    #1; check("R1 oe during reset", int'(pad_oe), 0);
    rst_n = 1'b1;
    idle(4);
    rd_check("R1 dir after reset", 3'd4, 8'h00);

    // R3: register writes and read-back
    wr(3'd0, 8'hA5);
    wr(3'd4, 8'h0F);
    rd_check("R3 dir readback", 3'd4, 8'h0F);
    pin_in = 8'h3C;
    idle(3);
    rd_check("R6 mixed read", 3'd0, 8'h35);  // low nibble latch 5, high nibble pins 3
    check("R4 oe follows dir", int'(pad_oe), 8'h0F);

    // R8: two-edge synchronizer latency
    @(negedge clk); #2; bus_addr = 3'd0; pin_in = 8'hC3;
    @(negedge clk); #1; check("R8 one edge, old level", int'(bus_rdata) & 8'hF0, 8'h30);
    @(negedge clk); #1; check("R8 two edges, new level", int'(bus_rdata) & 8'hF0, 8'hC0);

    // R5: keyboard override over driven pins
    wr(3'd4, 8'hFF);
    @(negedge clk); #2; kbw_en = 6'b100101;
    @(negedge clk); #1;
    check("R5 oe overridden", int'(pad_oe), 8'hFF & ~8'h4A);
    check("R5 pullups", int'(pad_pu), 8'h4A);
    rd_check("R6 kbw pin with dir 1 reads latch", 3'd0, 8'hA5);
    kbw_en = 6'h3F;
    idle(1);
    check("R5 edge pins no pullup", int'(pad_pu) & 8'h81, 0);
    kbw_en = 6'h00;

    // R9: unmapped addresses
    wr(3'd2, 8'h00);
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h00);
    rd_check("R9 latch untouched", 3'd0, 8'hA5);
    rd_check("R9 dir untouched", 3'd4, 8'hFF);
    for (int a = 1; a < 8; a++)
      if (a != 4) rd_check("R9 unmapped read", 3'(a), 0);

    // R7: latch before direction switch, no stale value
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h3C);
    @(negedge clk); #2; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'hFF;
    @(negedge clk); #1;
    check("R7 first enabled cycle oe", int'(pad_oe), 8'hFF);
    check("R7 first enabled cycle value", int'(pad_out), 8'h3C);
    #1; bus_wr = 1'b0; bus_addr = 3'd0;

    // R2: latch survives reset
    wr(3'd0, 8'h96);
    @(negedge clk); #2; rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 oe cleared by reset", int'(pad_oe), 0);
    check("R2 pad_out kept in reset", int'(pad_out), 8'h96);
    #1; rst_n = 1'b1;
    idle(3);
    rd_check("R1 dir cleared", 3'd4, 8'h00);
    wr(3'd4, 8'hFF);
    rd_check("R2 latch kept", 3'd0, 8'h96);

    // Mixed traffic, compared every cycle against the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk); #2;
      bus_wr    = ($urandom_range(0, 2) == 0);
      bus_addr  = 3'($urandom_range(0, 7));
      bus_wdata = 8'($urandom);
      pin_in    = 8'($urandom);
      kbw_en    = 6'($urandom);
    end
    bus_wr = 1'b0;
    idle(3);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule